// File: doc/BRIEF.md
# Cluster performance monitor

A performance monitor shared by the cores of a cluster. It holds a parameterised number of 32-bit event counters and one 64-bit cycle counter, reached through a single-cycle word-addressed register port. Each event counter is bound to one of 64 event input lines by a programmed event number and advances once for every clock cycle in which that line carries a pulse. The cycle counter advances once per clock. A level interrupt is raised while any counter that has wrapped, and whose interrupt enable is set, is still unacknowledged.

Every per-counter control is a 32-bit bitmap with one rule: bit i is event counter i for i below N, and bit 31 is always the cycle counter. The count enables, interrupt enables and overflow status all follow it, and so does the counter selector. Software binds an event counter to an event, and preloads or reads its value, by first writing the counter's index to the selector. The overflow status clears when it is read, so one read both reports and acknowledges.

Reads are combinational: `bus_rdata` is valid in the same cycle as `bus_sel` with `bus_wr` low. Writes take effect at the clock edge. Register word addresses: 0 control, 1 enable set, 2 enable clear, 3 interrupt-enable set, 4 interrupt-enable clear, 5 overflow status, 6 selector, 7 selected event number, 8 selected counter value, 9 cycle counter low word, 10 cycle counter high word, 11 and 12 the event-presence words (events 0-31, events 32-63).

Top module: `cluster_pmu`

## Requirements
- R1: After reset all counters, both enable masks, the overflow status, the selector, every event number and the global enable are zero, and `irq` is low.
- R2: A control read returns the global enable in bit 0, zeros in bits 2:1, N in bits 15:11, the identification code in bits 23:16 and the implementer code in bits 31:24.
- R3: While control bit 0 is clear no counter advances, whatever its own enable bit.
- R4: An event counter with its enable bit and the global enable set adds one for each cycle in which `evt_in[k]` is high, k being its event number (field bits 5:0); an event counter bound to event 0x11 never advances.
- R5: The cycle counter (bitmap bit 31) adds one on every clock while it and the global enable are set, carrying from the low word into the high word; each word is writable on its own.
- R6: A counter that wraps from all ones to zero sets its bit in the overflow status; reading the status returns the set bits and clears them in the same access, while a wrap in that very cycle still sets its bit.
- R7: `irq` is high exactly while some overflow status bit is set whose interrupt enable bit is also set.
- R8: Writing ones to a set or clear register sets or clears the matching enable bits; bits of counters that do not exist (N to 30) stay zero, and reading either set or clear address returns the current mask.
- R9: A selector write whose index (bits 4:0) is neither below N nor 31 is ignored; with index 31 selected the event-number register reads 0x11.
- R10: Writing control bit 1 as one zeroes every event counter and leaves the cycle counter alone; writing bit 2 as one zeroes the cycle counter and leaves the event counters alone.
- R11: Writing the selected-value register loads the selected event counter, so software can preload any value and read it back.
- R12: The two event-presence words read as the low and high halves of a 64-bit parameter in which bit k marks event number k as implemented; writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| evt_in | input | 64 | One-cycle event pulses, one line per event number |
| irq | output | 1 | Level overflow interrupt |

## Verification
The assertions take for granted that the register port is quiet while reset is held and that a read of the overflow status lasts a single cycle, since each cycle of a read counts as a separate acknowledge. The bench drives every access for exactly one clock, drives event pulses only between accesses, and keeps `evt_in` at zero while counters are being programmed, so each count it predicts comes from the pulses it chose alone. The sweep binds every counter in turn to every event number and mixes the chosen line with pulses on all the other lines, which exercises the selection and the cycle-event exclusion together.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int          CYC_IDX = 31;
  localparam int          EVT_W   = 6;
  localparam int          NUM_EVT = 1 << EVT_W;
  localparam logic [5:0]  CYC_EVT = 6'h11;

  typedef enum logic [3:0] {
    RA_CTRL   = 4'd0,
    RA_EN_SET = 4'd1,
    RA_EN_CLR = 4'd2,
    RA_IE_SET = 4'd3,
    RA_IE_CLR = 4'd4,
    RA_OVF    = 4'd5,
    RA_SEL    = 4'd6,
    RA_TYPE   = 4'd7,
    RA_COUNT  = 4'd8,
    RA_CYC_LO = 4'd9,
    RA_CYC_HI = 4'd10,
    RA_EVID0  = 4'd11,
    RA_EVID1  = 4'd12
  } reg_addr_e;

  // Bitmap of counters that exist: 0..n-1 plus the cycle counter.
  function automatic logic [31:0] valid_mask(input int n);
    logic [31:0] m;
    m = 32'h8000_0000;
    for (int k = 0; k < 31; k++) begin
      if (k < n) m[k] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic sel_legal(input logic [4:0] idx, input int n);
    return (int'(idx) < n) || (idx == 5'd31);
  endfunction

  function automatic logic [31:0] ctrl_word(input logic en, input int n,
                                            input logic [7:0] id,
                                            input logic [7:0] impl);
    logic [4:0] nn;
    nn = 5'(n);
    return {impl, id, nn, 10'b0, en};
  endfunction

  // Read-to-clear with new wraps taking precedence.
  function automatic logic [31:0] ovf_next(input logic [31:0] cur,
                                           input logic rd,
                                           input logic [31:0] wraps);
    return (rd ? 32'h0 : cur) | wraps;
  endfunction

endpackage

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter #(
  parameter int CW    = 32,
  parameter int EVT_W = 6,
  localparam int NEVT = 1 << EVT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [NEVT-1:0]  evt_in,
  input  logic             type_we,
  input  logic [EVT_W-1:0] type_wdata,
  input  logic             val_we,
  input  logic [CW-1:0]    val_wdata,
  input  logic             clr,
  output logic [CW-1:0]    value,
  output logic [EVT_W-1:0] evtype,
  output logic             wrap
);

  logic hit;

  assign hit  = run && (evtype != EVT_W'(pmu_pkg::CYC_EVT)) && evt_in[evtype];
  assign wrap = hit && !val_we && !clr && (value == {CW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value  <= '0;
      evtype <= '0;
    end else begin
      if (type_we) evtype <= type_wdata;
      if (clr)         value <= '0;
      else if (val_we) value <= val_wdata;
      else if (hit)    value <= value + 1'b1;
    end
  end

endmodule

// File: rtl/pmu_cyc_counter.sv
module pmu_cyc_counter #(
  parameter int CW = 64,
  localparam int HW = CW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic          clr,
  input  logic [HW-1:0] wdata,
  output logic [CW-1:0] value,
  output logic          wrap
);

  logic any_wr;

  assign any_wr = lo_we || hi_we || clr;
  assign wrap   = run && !any_wr && (value == {CW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (clr) begin
      value <= '0;
    end else if (lo_we || hi_we) begin
      if (lo_we) value[HW-1:0]  <= wdata;
      if (hi_we) value[CW-1:HW] <= wdata;
    end else if (run) begin
      value <= value + 1'b1;
    end
  end

endmodule

// File: rtl/cluster_pmu.sv
module cluster_pmu #(
  parameter int          NUM_CNT   = 4,
  parameter logic [7:0]  ID_CODE   = 8'h5A,
  parameter logic [7:0]  IMPL_CODE = 8'h41,
  parameter logic [63:0] EVT_IMPL  = 64'h0000_0F00_2E02_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [63:0] evt_in,
  output logic        irq
);
  import pmu_pkg::*;

  localparam logic [31:0] VMASK = valid_mask(NUM_CNT);

  logic        glob_en;
  logic [31:0] cnt_en_q, int_en_q, ovf_q;
  logic [4:0]  sel_q;

  logic        wr_any, rd_any, wr_ctrl;
  logic        ovf_rd;
  logic [31:0] ev_val  [32];
  logic [5:0]  ev_type [32];
  logic [31:0] ev_wrap;
  logic [31:0] wrap_vec;
  logic [63:0] cyc_val;
  logic        cyc_wrap, cyc_lo_we, cyc_hi_we, cyc_clr, cyc_wr;

  assign wr_any  = bus_sel && bus_wr;
  assign rd_any  = bus_sel && !bus_wr;
  assign wr_ctrl = wr_any && (bus_addr == RA_CTRL);
  assign ovf_rd  = rd_any && (bus_addr == RA_OVF);

  // Event counter slots; slots past N and slot 31 stay empty.
  for (genvar j = 0; j < 32; j++) begin : g_slot
    if (j < NUM_CNT && j != CYC_IDX) begin : g_cnt
      pmu_evt_counter #(.CW(32), .EVT_W(EVT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (glob_en && cnt_en_q[j]),
        .evt_in     (evt_in),
        .type_we    (wr_any && (bus_addr == RA_TYPE) && (sel_q == 5'(j))),
        .type_wdata (bus_wdata[EVT_W-1:0]),
        .val_we     (wr_any && (bus_addr == RA_COUNT) && (sel_q == 5'(j))),
        .val_wdata  (bus_wdata),
        .clr        (wr_ctrl && bus_wdata[1]),
        .value      (ev_val[j]),
        .evtype     (ev_type[j]),
        .wrap       (ev_wrap[j])
      );
    end else begin : g_none
      assign ev_val[j]  = '0;
      assign ev_type[j] = '0;
      assign ev_wrap[j] = 1'b0;
    end
  end

  assign cyc_lo_we = wr_any && ((bus_addr == RA_CYC_LO) ||
                                ((bus_addr == RA_COUNT) && (sel_q == 5'd31)));
  assign cyc_hi_we = wr_any && (bus_addr == RA_CYC_HI);
  assign cyc_clr   = wr_ctrl && bus_wdata[2];
  assign cyc_wr    = cyc_lo_we || cyc_hi_we || cyc_clr;

  pmu_cyc_counter #(.CW(64)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (glob_en && cnt_en_q[CYC_IDX]),
    .lo_we (cyc_lo_we),
    .hi_we (cyc_hi_we),
    .clr   (cyc_clr),
    .wdata (bus_wdata),
    .value (cyc_val),
    .wrap  (cyc_wrap)
  );

  assign wrap_vec = ev_wrap | {cyc_wrap, 31'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en  <= 1'b0;
      cnt_en_q <= '0;
      int_en_q <= '0;
      ovf_q    <= '0;
      sel_q    <= '0;
    end else begin
      ovf_q <= ovf_next(ovf_q, ovf_rd, wrap_vec);
      if (wr_ctrl) glob_en <= bus_wdata[0];
      if (wr_any) begin
        case (bus_addr)
          RA_EN_SET: cnt_en_q <= cnt_en_q | (bus_wdata & VMASK);
          RA_EN_CLR: cnt_en_q <= cnt_en_q & ~bus_wdata;
          RA_IE_SET: int_en_q <= int_en_q | (bus_wdata & VMASK);
          RA_IE_CLR: int_en_q <= int_en_q & ~bus_wdata;
          RA_SEL: if (sel_legal(bus_wdata[4:0], NUM_CNT)) sel_q <= bus_wdata[4:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      case (bus_addr)
        RA_CTRL:   bus_rdata = ctrl_word(glob_en, NUM_CNT, ID_CODE, IMPL_CODE);
        RA_EN_SET,
        RA_EN_CLR: bus_rdata = cnt_en_q;
        RA_IE_SET,
        RA_IE_CLR: bus_rdata = int_en_q;
        RA_OVF:    bus_rdata = ovf_q;
        RA_SEL:    bus_rdata = {27'b0, sel_q};
        RA_TYPE:   bus_rdata = (sel_q == 5'd31) ? 32'(CYC_EVT) : 32'(ev_type[sel_q]);
        RA_COUNT:  bus_rdata = (sel_q == 5'd31) ? cyc_val[31:0] : ev_val[sel_q];
        RA_CYC_LO: bus_rdata = cyc_val[31:0];
        RA_CYC_HI: bus_rdata = cyc_val[63:32];
        RA_EVID0:  bus_rdata = EVT_IMPL[31:0];
        RA_EVID1:  bus_rdata = EVT_IMPL[63:32];
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign irq = |(ovf_q & int_en_q);

endmodule

// File: rtl/cluster_pmu_chk.sv
module cluster_pmu_chk #(
  parameter int NUM_CNT = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic        irq,
  input logic        glob_en,
  input logic [31:0] cnt_en_q,
  input logic [31:0] ovf_q,
  input logic        ovf_rd,
  input logic [63:0] cyc_val,
  input logic        cyc_wr,
  input logic [4:0]  sel_q,
  input logic [31:0] wrap_vec
);

  localparam logic [31:0] VMASK = pmu_pkg::valid_mask(NUM_CNT);

  assert_ctrl_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 4'd0) |-> (bus_rdata[2:1] == 2'b00));

  assert_cyc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(glob_en) && !$past(cyc_wr)) |-> (cyc_val == $past(cyc_val)));

  assert_cyc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(glob_en && cnt_en_q[31] && !cyc_wr) |-> (cyc_val == $past(cyc_val) + 64'd1));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ovf_rd) |-> (($past(ovf_q) & ~ovf_q) == 32'h0));

  assert_irq_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovf_rd) && ($past(wrap_vec) == 32'h0)) |-> !irq);

  assert_en_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_q & ~VMASK) == 32'h0);

  assert_sel_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_q) < NUM_CNT) || (sel_q == 5'd31));

endmodule

bind cluster_pmu cluster_pmu_chk #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .glob_en   (glob_en),
  .cnt_en_q  (cnt_en_q),
  .ovf_q     (ovf_q),
  .ovf_rd    (ovf_rd),
  .cyc_val   (cyc_val),
  .cyc_wr    (cyc_wr),
  .sel_q     (sel_q),
  .wrap_vec  (wrap_vec)
);

// File: tb/cluster_pmu_tb.sv
`timescale 1ns/1ps
module cluster_pmu_tb;

  localparam int          N     = 4;
  localparam logic [63:0] IMPL  = 64'h0000_0F00_2E02_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] evt_in = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cluster_pmu #(.NUM_CNT(N), .ID_CODE(8'h5A), .IMPL_CODE(8'h41), .EVT_IMPL(IMPL)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input logic [63:0] v, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      evt_in = v;
      @(posedge clk); #1;
      evt_in = '0;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    logic [63:0] cyc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R2 reset state
    rd(4'd0, d);  chk("R2 ctrl after reset", d, {8'h41, 8'h5A, 5'(N), 10'b0, 1'b0});
    rd(4'd1, d);  chk("R1 enable mask", d, 0);
    rd(4'd3, d);  chk("R1 irq enable mask", d, 0);
    rd(4'd5, d);  chk("R1 overflow status", d, 0);
    rd(4'd6, d);  chk("R1 selector", d, 0);
    rd(4'd7, d);  chk("R1 event number", d, 0);
    rd(4'd8, d);  chk("R1 counter 0", d, 0);
    rd(4'd9, d);  chk("R1 cycle low", d, 0);
    chk("R1 irq", irq, 0);

    // R12 event-presence words, read-only
    wr(4'd11, 32'h1234_5678); wr(4'd12, 32'hFFFF_FFFF);
    rd(4'd11, d); chk("R12 presence low", d, IMPL[31:0]);
    rd(4'd12, d); chk("R12 presence high", d, IMPL[63:32]);

    // R8 set/clear masks
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, d); chk("R8 enable set all", d, 32'h8000_000F);
    wr(4'd2, 32'h0000_0001); rd(4'd2, d); chk("R8 enable clear bit0", d, 32'h8000_000E);
    wr(4'd1, 32'h0000_0001); rd(4'd1, d); chk("R8 enable set bit0", d, 32'h8000_000F);
    wr(4'd3, 32'hFFFF_FFFF); rd(4'd4, d); chk("R8 irq enable set all", d, 32'h8000_000F);
    wr(4'd4, 32'hFFFF_FFFF); rd(4'd3, d); chk("R8 irq enable clear all", d, 0);

    // R9 selector legality
    wr(4'd6, 2);  wr(4'd6, 9); rd(4'd6, d); chk("R9 illegal select ignored", d, 2);
    wr(4'd6, 30); rd(4'd6, d); chk("R9 index 30 ignored", d, 2);
    wr(4'd6, 31); rd(4'd6, d); chk("R9 cycle select", d, 31);
    rd(4'd7, d);  chk("R9 cycle event number", d, 32'h11);

    // R2 control bits 2:1 read as zero
    wr(4'd0, 32'h7); rd(4'd0, d); chk("R2 ctrl enabled", d, {8'h41, 8'h5A, 5'(N), 10'b0, 1'b1});

    // R4 sweep: every counter against every event number
    for (int i = 0; i < N; i++) begin
      for (int e = 0; e < 64; e++) begin
        logic [63:0] v;
        v = 64'd1 << e;
        wr(4'd6, i); wr(4'd7, e); wr(4'd8, 0);
        pulse(v, 3);
        pulse(~v, 2);
        rd(4'd8, d);
        chk($sformatf("R4 counter %0d event %0d", i, e), d, (e == 17) ? 0 : 3);
      end
    end

    // R3 global enable gates everything
    wr(4'd0, 0); wr(4'd6, 0); wr(4'd7, 5); wr(4'd8, 0);
    pulse(64'd1 << 5, 4);
    rd(4'd8, d); chk("R3 event counter held", d, 0);
    rd(4'd9, d); rd(4'd9, d2); chk("R3 cycle counter held", d2, d);
    // own enable off
    wr(4'd0, 1); wr(4'd2, 1);
    pulse(64'd1 << 5, 4);
    rd(4'd8, d); chk("R4 counter disabled", d, 0);
    wr(4'd1, 1);
    pulse(64'd1 << 5, 2);
    rd(4'd8, d); chk("R4 counter re-enabled", d, 2);

    // R11 preload, R6 wrap, R7 interrupt
    wr(4'd6, 1); wr(4'd7, 5); wr(4'd8, 32'hFFFF_FFFE);
    rd(4'd8, d); chk("R11 preload readback", d, 32'hFFFF_FFFE);
    pulse(64'd1 << 5, 2);
    rd(4'd8, d); chk("R6 counter wrapped to zero", d, 0);
    chk("R7 irq masked", irq, 0);
    wr(4'd3, 32'h2);
    #1 chk("R7 irq raised", irq, 1);
    rd(4'd5, d); chk("R6 status bit 1", d, 32'h2);
    #1 chk("R7 irq after acknowledge", irq, 0);
    rd(4'd5, d); chk("R6 status cleared by read", d, 0);
    wr(4'd4, 32'hFFFF_FFFF);

    // R5 cycle counter with carry
    wr(4'd0, 0); wr(4'd9, 32'hFFFF_FFF0); wr(4'd10, 32'h12);
    wr(4'd0, 1);
    repeat (20) @(negedge clk);
    wr(4'd0, 0);
    rd(4'd9, d); rd(4'd10, d2); cyc = {d2, d};
    chk("R5 cycle count with carry", cyc, 64'h12_FFFF_FFF0 + 64'd21);
    // R6 cycle counter wrap
    wr(4'd9, 32'hFFFF_FFFF); wr(4'd10, 32'hFFFF_FFFF);
    wr(4'd0, 1); wr(4'd0, 0);
    rd(4'd9, d); rd(4'd10, d2); chk("R6 cycle wrapped", {d2, d}, 0);
    rd(4'd5, d); chk("R6 cycle status bit 31", d, 32'h8000_0000);

    // R10 separate reset bits
    wr(4'd6, 0); wr(4'd8, 100); wr(4'd9, 50); wr(4'd10, 0);
    wr(4'd0, 32'h2);
    rd(4'd8, d); chk("R10 event counters zeroed", d, 0);
    rd(4'd9, d); chk("R10 cycle kept", d, 50);
    wr(4'd8, 7);
    wr(4'd0, 32'h4);
    rd(4'd9, d); chk("R10 cycle zeroed", d, 0);
    rd(4'd8, d); chk("R10 event counter kept", d, 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule